// File: doc/BRIEF.md
# Watchdog Down-Counter with Selectable Time-Out Response

This block is a watchdog built around a 24-bit down-counter. The counter steps once per pulse of a slow tick enable, which stands in for a dedicated low-frequency oscillator. At a 10 kHz tick, each count is 100 µs. The counter loads a reload value held in three byte-wide registers. It loads when the watchdog is switched on, and again whenever the processor strobes a refresh. Software must refresh the counter before it runs out, or a time-out fires.

A static option input chooses what a time-out does:

- **Reset mode:** the block emits a one-cycle reset request and reloads the counter.
- **Interrupt mode:** the block pulses an interrupt request and sets a status flag. The counter is left at zero, so it wraps to all-ones on the next tick and keeps counting.

If a stop-mode input is high when an interrupt-mode time-out occurs, the block also pulses a stop-recovery request and sets a second flag. A debug input reloads the counter on every cycle, so no time-out can happen while debugging.

A small byte-wide register port gives access to the reload bytes and the two status flags. Software clears each flag by writing 1 to it.

Top module: `wdog_top`

## Requirements
- R1: After reset, all three request outputs are low, both flags read 0, and the reload value is 0xFFFFFF.
- R2: Register address 1 holds reload bits 23:16, address 2 holds bits 15:8, and address 3 holds bits 7:0; each reads back what was written. Address 0 reads the timeout flag in bit 7, the stop flag in bit 6, and 0 in the other bits.
- R3: A rising edge of the enable loads the reload value N. The time-out fires on the Nth tick after that edge, and not before.
- R4: A refresh strobe reloads the counter. The next time-out then needs N further ticks.
- R5: A refresh in the same cycle as the tick that would end the count wins. No time-out is reported, and the counter restarts from N.
- R6: With the option input high (reset mode), a time-out gives a one-cycle reset request. There is no interrupt and no flag change, and the counter reloads, so the next time-out follows N ticks later.
- R7: With the option input low (interrupt mode), a time-out gives a one-cycle interrupt and sets the timeout flag. The counter stays at zero and then wraps to 0xFFFFFF, so no time-out follows soon after.
- R8: While the debug input is high, no time-out occurs, however many ticks arrive. After release, counting starts from N.
- R9: An interrupt-mode time-out with the stop input high also pulses the stop-recovery output and sets the stop flag. With the stop input low, the stop-recovery output stays low.
- R10: Writing 1 to a flag bit at address 0 clears that flag, and writing 0 leaves it unchanged.
- R11: While the enable is low, the counter holds and no request is raised. Enabling again reloads N.
- R12: The reset, interrupt and stop-recovery requests are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow-domain count enable, one pulse per count |
| en_i | input | 1 | Watchdog enable |
| refresh_i | input | 1 | Processor refresh strobe |
| debug_i | input | 1 | Debug mode, holds the counter at the reload value |
| stop_i | input | 1 | Device is in stop mode |
| rst_sel_i | input | 1 | Time-out response: 1 reset request, 0 interrupt |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| rst_req_o | output | 1 | Reset request pulse |
| irq_o | output | 1 | Interrupt request pulse |
| stop_wake_o | output | 1 | Stop-mode recovery request pulse |

## Verification
The bound checker watches several properties on every cycle:

- each request lasts a single cycle;
- the reset and interrupt requests never coincide;
- a stop-recovery pulse is always paired with an interrupt and the stop flag;
- an interrupt always leaves the counter at zero with the timeout flag set;
- debug mode and a low enable keep every request low, and a low enable freezes the counter.

The bench scenarios cover what a property cannot express compactly: that the time-out lands exactly on the Nth tick after enable or refresh, the same-cycle race between refresh and the last tick, the reload after a reset-mode time-out versus the long wrap after an interrupt-mode one, the flag clearing, and the reload on re-enable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WDT_BIT  = 7;
  localparam int unsigned STOP_BIT = 6;

  function automatic int unsigned addr_w(input int unsigned cnt_w);
    return $clog2(cnt_w / BYTE_W + 1);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1,
  parameter int unsigned AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              set_wdt_i,
  input  logic              set_stop_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic              wdt_flag_o,
  output logic              stop_flag_o
);
  localparam int unsigned NB = CNT_W / BYTE_W;

  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i == '0);

  // address 1 is the most significant byte
  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int unsigned SEL = NB - b;
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                byte_q <= RELOAD_RST[b*BYTE_W +: BYTE_W];
      else if (we_i && addr_i == SEL[AW-1:0])     byte_q <= wdata_i;
    end
    assign reload_o[b*BYTE_W +: BYTE_W] = byte_q;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_flag_o  <= 1'b0;
      stop_flag_o <= 1'b0;
    end else begin
      if (set_wdt_i)                        wdt_flag_o  <= 1'b1;
      else if (ctrl_wr && wdata_i[WDT_BIT]) wdt_flag_o  <= 1'b0;
      if (set_stop_i)                        stop_flag_o <= 1'b1;
      else if (ctrl_wr && wdata_i[STOP_BIT]) stop_flag_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[WDT_BIT]  = wdt_flag_o;
      rdata_o[STOP_BIT] = stop_flag_o;
    end
    for (int b = 0; b < NB; b++) begin
      if (addr_i == AW'(NB - b)) rdata_o = reload_o[b*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             refresh_i,
  input  logic             debug_i,
  input  logic             rst_sel_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             timeout_o
);
  logic             en_q;
  logic             en_rise, load, dec;
  logic [CNT_W-1:0] cnt_d;

  assign en_rise   = en_i && !en_q;
  assign load      = en_i && (en_rise || debug_i || refresh_i);
  assign dec       = en_i && !load && tick_i;
  // the tick that brings the count from one to zero is the time-out
  assign timeout_o = dec && (cnt_o == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_o;
    if (load)                        cnt_d = reload_i;
    else if (timeout_o && rst_sel_i) cnt_d = reload_i;
    else if (dec)                    cnt_d = cnt_o - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_o <= '0;
    end else begin
      en_q  <= en_i;
      cnt_o <= cnt_d;
    end
  end
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic timeout_i,
  input  logic rst_sel_i,
  input  logic stop_i,
  output logic set_wdt_o,
  output logic set_stop_o,
  output logic rst_req_o,
  output logic irq_o,
  output logic stop_wake_o
);
  assign set_wdt_o  = timeout_i && !rst_sel_i;
  assign set_stop_o = set_wdt_o && stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o   <= 1'b0;
      irq_o       <= 1'b0;
      stop_wake_o <= 1'b0;
    end else begin
      rst_req_o   <= timeout_i && rst_sel_i;
      irq_o       <= set_wdt_o;
      stop_wake_o <= set_stop_o;
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1,
  parameter int unsigned ADDR_W = wdog_pkg::addr_w(CNT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              refresh_i,
  input  logic              debug_i,
  input  logic              stop_i,
  input  logic              rst_sel_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              rst_req_o,
  output logic              irq_o,
  output logic              stop_wake_o
);
  logic [CNT_W-1:0] reload_w, cnt_w;
  logic             timeout_w, set_wdt_w, set_stop_w;
  logic             wdt_flag_w, stop_flag_w;

  wdog_regs #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST), .AW(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .set_wdt_i(set_wdt_w), .set_stop_i(set_stop_w),
    .reload_o(reload_w), .wdt_flag_o(wdt_flag_w), .stop_flag_o(stop_flag_w)
  );

  wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .en_i, .refresh_i, .debug_i, .rst_sel_i,
    .reload_i(reload_w), .cnt_o(cnt_w), .timeout_o(timeout_w)
  );

  wdog_resp u_resp (
    .clk_i, .rst_ni, .timeout_i(timeout_w), .rst_sel_i, .stop_i,
    .set_wdt_o(set_wdt_w), .set_stop_o(set_stop_w),
    .rst_req_o, .irq_o, .stop_wake_o
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             debug_i,
  input logic             rst_req_o,
  input logic             irq_o,
  input logic             stop_wake_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic             wdt_flag_i,
  input logic             stop_flag_i
);
  a_r12_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r12_rst_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && rst_req_o));
  a_r9_wake_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_wake_o |-> (irq_o && stop_flag_i));
  a_r7_flag_on_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wdt_flag_i);
  a_r7_zero_after_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cnt_i == '0));
  a_r8_debug_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_i |=> (!irq_o && !rst_req_o));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_i) && !irq_o && !rst_req_o));
endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .debug_i(debug_i),
  .rst_req_o(rst_req_o), .irq_o(irq_o), .stop_wake_o(stop_wake_o),
  .cnt_i(cnt_w), .wdt_flag_i(wdt_flag_w), .stop_flag_i(stop_flag_w)
);

// File: tb/wdog_top_tb.sv
module wdog_top_tb_top;
  localparam int unsigned N = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, en = 1'b0, refresh = 1'b0, debug = 1'b0;
  logic       stop = 1'b0, rst_sel = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rst_req, irq, wake;
  int         checks = 0, fails = 0;

  always #5 clk = ~clk;

  wdog_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en), .refresh_i(refresh),
    .debug_i(debug), .stop_i(stop), .rst_sel_i(rst_sel), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rst_req_o(rst_req), .irq_o(irq), .stop_wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic outs_chk(input logic r, input logic i, input logic w, input string req);
    chk({req, " rst_req"}, rst_req, r);
    chk({req, " irq"}, irq, i);
    chk({req, " wake"}, wake, w);
  endtask

  task automatic do_tick(input logic with_refresh);
    @(negedge clk); tick = 1'b1; refresh = with_refresh;
    @(negedge clk); tick = 1'b0; refresh = 1'b0;
  endtask

  task automatic quiet_ticks(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      do_tick(1'b0);
      outs_chk(1'b0, 1'b0, 1'b0, req);
    end
  endtask

  task automatic do_refresh();
    @(negedge clk); refresh = 1'b1;
    @(negedge clk); refresh = 1'b0;
  endtask

  task automatic t_reset();
    outs_chk(1'b0, 1'b0, 1'b0, "R1");
    rd_chk(2'd0, 8'h00, "R1 flags");
    rd_chk(2'd1, 8'hFF, "R1 reload hi");
    rd_chk(2'd2, 8'hFF, "R1 reload mid");
    rd_chk(2'd3, 8'hFF, "R1 reload lo");
  endtask

  task automatic t_regs();
    wr(2'd1, 8'h12); wr(2'd2, 8'h34); wr(2'd3, 8'h56);
    rd_chk(2'd1, 8'h12, "R2 hi");
    rd_chk(2'd2, 8'h34, "R2 mid");
    rd_chk(2'd3, 8'h56, "R2 lo");
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'(N));
    rd_chk(2'd3, 8'(N), "R2 lo rewrite");
    rd_chk(2'd0, 8'h00, "R2 ctrl");
  endtask

  task automatic t_enable_irq();
    rst_sel = 1'b0;
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    quiet_ticks(N - 1, "R3 early");
    do_tick(1'b0);
    outs_chk(1'b0, 1'b1, 1'b0, "R3 R7 timeout");
    @(negedge clk);
    outs_chk(1'b0, 1'b0, 1'b0, "R12 pulse");
    rd_chk(2'd0, 8'h80, "R7 flag");
    quiet_ticks(3 * N, "R7 wrap");
    wr(2'd0, 8'h00);
    rd_chk(2'd0, 8'h80, "R10 write0 keeps");
    wr(2'd0, 8'h80);
    rd_chk(2'd0, 8'h00, "R10 clear");
  endtask

  task automatic t_refresh();
    do_refresh();
    quiet_ticks(N - 2, "R4 partial");
    do_refresh();
    quiet_ticks(N - 1, "R4 after refresh");
    do_tick(1'b0);
    outs_chk(1'b0, 1'b1, 1'b0, "R4 timeout");
    wr(2'd0, 8'h80);
  endtask

  task automatic t_race();
    do_refresh();
    quiet_ticks(N - 1, "R5 lead");
    do_tick(1'b1);
    outs_chk(1'b0, 1'b0, 1'b0, "R5 race");
    quiet_ticks(N - 1, "R5 restart");
    do_tick(1'b0);
    outs_chk(1'b0, 1'b1, 1'b0, "R5 later timeout");
    wr(2'd0, 8'h80);
  endtask

  task automatic t_reset_mode();
    rst_sel = 1'b1;
    do_refresh();
    quiet_ticks(N - 1, "R6 early");
    do_tick(1'b0);
    outs_chk(1'b1, 1'b0, 1'b0, "R6 timeout");
    @(negedge clk);
    outs_chk(1'b0, 1'b0, 1'b0, "R12 rst pulse");
    rd_chk(2'd0, 8'h00, "R6 no flag");
    quiet_ticks(N - 1, "R6 reload");
    do_tick(1'b0);
    outs_chk(1'b1, 1'b0, 1'b0, "R6 second timeout");
    rst_sel = 1'b0;
  endtask

  task automatic t_debug();
    do_refresh();
    @(negedge clk); debug = 1'b1;
    quiet_ticks(4 * N, "R8 debug");
    @(negedge clk); debug = 1'b0;
    quiet_ticks(N - 1, "R8 release");
    do_tick(1'b0);
    outs_chk(1'b0, 1'b1, 1'b0, "R8 timeout after release");
    wr(2'd0, 8'h80);
  endtask

  task automatic t_stop();
    stop = 1'b1;
    do_refresh();
    quiet_ticks(N - 1, "R9 early");
    do_tick(1'b0);
    outs_chk(1'b0, 1'b1, 1'b1, "R9 stop timeout");
    rd_chk(2'd0, 8'hC0, "R9 flags");
    wr(2'd0, 8'h40);
    rd_chk(2'd0, 8'h80, "R10 clear stop only");
    wr(2'd0, 8'h80);
    rd_chk(2'd0, 8'h00, "R10 clear wdt");
    stop = 1'b0;
  endtask

  task automatic t_disable();
    do_refresh();
    quiet_ticks(2, "R11 before");
    @(negedge clk); en = 1'b0;
    quiet_ticks(4 * N, "R11 disabled");
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    quiet_ticks(N - 1, "R11 reenable reload");
    do_tick(1'b0);
    outs_chk(1'b0, 1'b1, 1'b0, "R11 timeout");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_enable_irq();
    t_refresh();
    t_race();
    t_reset_mode();
    t_debug();
    t_stop();
    t_disable();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule